// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

This block sits between a video timing generator and the pins of a parallel RGB panel. Each clock it takes one 24-bit pixel (red in bits 23:16, green in 15:8, blue in 7:0) together with horizontal sync, vertical sync and data-enable. It can swap the colour channels, and it packs the result onto a 24-line output bus in one of several 16-, 18- or 24-bit layouts. It also drives the sync pins, the output-enable pin and a copy of the pixel clock.

Software sets up the block through one control word on a small register port. That word selects the channel order, the packing layout, and three settings for each control pin: polarity, launch edge and forced disable. It also selects what the output-enable pin carries and switches the whole output path on or off. Every address other than the control word reads back a fixed identification constant. Software can use that constant to confirm the block is present.

Top module: `rgb_out_fmt`

## Requirements
- R1: A read at address 0 returns the control word in bits 16:0 with bits 31:17 zero. A read at any other address returns 32'h00647069. Reads are combinational.
- R2: A write to any address other than 0 leaves the control word and all outputs unchanged.
- R3: Control bits 15:14 reorder the channels before packing. For code 0 the red, green and blue slots carry (R,G,B). Code 1 gives (B,G,R), code 2 gives (G,R,B) and code 3 gives (B,R,G).
- R4: Control bits 13:11 select the layout, with bit 23 as the MSB. When a field is narrower than 8 bits it takes the channel's top bits, and every unnamed bit is 0. The layouts are:
  - 1 puts red at 15:11, green at 10:5 and blue at 4:0.
  - 2 puts red at 20:16, green at 13:8 and blue at 4:0.
  - 3 puts red at 21:17, green at 13:8 and blue at 5:1.
  - 4 puts red at 17:12, green at 11:6 and blue at 5:0.
  - 5 puts red at 21:16, green at 13:8 and blue at 5:0.
  - 6 puts red at 23:16, green at 15:8 and blue at 7:0.
- R5: Layout codes 0 and 7 drive an all-zero data bus.
- R6: Data, sync and enable outputs are registered. Each one shows the inputs captured at a rising edge from that edge on, so all of them share a one-cycle latency.
- R7: Bits 9, 8 and 7 invert hsync, vsync and the output-enable pin respectively.
- R8: While the block is enabled, the clock output equals clk XOR bit 10.
- R9: Bits 3, 2 and 1 force hsync, vsync and the output-enable pin inactive. A forced pin sits at its invert bit's value.
- R10: Bits 6, 5 and 4 delay the launch of hsync, vsync and the output-enable pin to the following falling clock edge, half a cycle later than normal.
- R11: When bit 16 is 1, the output-enable pin carries data-enable. When bit 16 is 0, it carries composite sync (hsync OR vsync), still subject to bits 7, 4 and 1.
- R12: While bit 0 is 0, every output (data, syncs, enable and clock) is 0, from the edge that writes the 0 onwards.
- R13: On a 0-to-1 change of bit 0, the first rising edge after the write clears the pipeline. Data then shows 0 for one cycle before pixels flow.
- R14: After reset, the control word is 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | ADDR_W | Register byte address |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 17 | Register write data |
| cfg_rdata | output | RD_W | Register read data |
| pix_in | input | 24 | Pixel, R 23:16, G 15:8, B 7:0 |
| hs_in | input | 1 | Horizontal sync from timing generator |
| vs_in | input | 1 | Vertical sync from timing generator |
| de_in | input | 1 | Data-enable from timing generator |
| vid_data | output | 24 | Packed output data bus |
| vid_hsync | output | 1 | Horizontal sync pin |
| vid_vsync | output | 1 | Vertical sync pin |
| vid_oe | output | 1 | Output-enable / composite sync pin |
| vid_pclk | output | 1 | Pixel clock output |

## Verification
Register reads are combinational, so they are checked half a nanosecond after the address settles.

A pixel or sync value driven just after edge N becomes visible at the pins just after edge N+1 when launched on the rising edge. With falling-edge launch it becomes visible just after the following falling edge. Every vector is therefore checked 2.5 ns after its capture edge, a point both launch modes have reached. The falling-edge and latency tests also sample 0.5 ns after the capture edge and just before it, to show the half-cycle delay and that nothing changes early.

After any control write, the first edge is left unused, because a fresh enable clears the pipeline there.

// File: rtl/rof_pkg.sv
package rof_pkg;
  localparam int CH_W   = 8;
  localparam int PIX_W  = 3 * CH_W;
  localparam int CTRL_W = 17;

  typedef struct packed {
    logic       oe_mode;   // 1: data-enable on oe pin, 0: composite sync
    logic [1:0] order;
    logic [2:0] fmt;
    logic       pclk_inv;
    logic       hs_inv;
    logic       vs_inv;
    logic       oe_inv;
    logic       hs_neg;
    logic       vs_neg;
    logic       oe_neg;
    logic       hs_dis;
    logic       vs_dis;
    logic       oe_dis;
    logic       enable;
  } ctrl_t;

  // Channel slot exchange, applied ahead of packing.
  function automatic logic [PIX_W-1:0] shuffle(input logic [1:0] ord,
                                               input logic [PIX_W-1:0] p);
    logic [CH_W-1:0] r, g, b;
    r = p[3*CH_W-1:2*CH_W];
    g = p[2*CH_W-1:CH_W];
    b = p[CH_W-1:0];
    case (ord)
      2'd0:    return {r, g, b};
      2'd1:    return {b, g, r};
      2'd2:    return {g, r, b};
      default: return {b, r, g};
    endcase
  endfunction

  // Bus layouts; narrow fields keep the channel MSBs.
  function automatic logic [PIX_W-1:0] pack_bus(input logic [2:0] fmt,
                                                input logic [PIX_W-1:0] p);
    logic [CH_W-1:0] r, g, b;
    r = p[3*CH_W-1:2*CH_W];
    g = p[2*CH_W-1:CH_W];
    b = p[CH_W-1:0];
    case (fmt)
      3'd1:    return {8'b0, r[7:3], g[7:2], b[7:3]};
      3'd2:    return {3'b0, r[7:3], 2'b0, g[7:2], 3'b0, b[7:3]};
      3'd3:    return {2'b0, r[7:3], 3'b0, g[7:2], 2'b0, b[7:3], 1'b0};
      3'd4:    return {6'b0, r[7:2], g[7:2], b[7:2]};
      3'd5:    return {2'b0, r[7:2], 2'b0, g[7:2], 2'b0, b[7:2]};
      3'd6:    return {r, g, b};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rof_regs.sv
module rof_regs
  import rof_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          RD_W    = 32,
  parameter logic [31:0] ID_WORD = 32'h00647069
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [RD_W-1:0]   cfg_rdata,
  output ctrl_t             ctrl,
  output logic              start
);
  localparam int PAD_W = RD_W - CTRL_W;

  logic ctrl_hit;
  logic en_prev;

  assign ctrl_hit = (cfg_addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      en_prev <= 1'b0;
    end else begin
      en_prev <= ctrl.enable;
      if (cfg_we && ctrl_hit) ctrl <= ctrl_t'(cfg_wdata);
    end
  end

  // High for the one edge after the enable bit first reads as set.
  assign start = ctrl.enable & ~en_prev;

  assign cfg_rdata = ctrl_hit ? {{PAD_W{1'b0}}, ctrl} : RD_W'(ID_WORD);
endmodule

// File: rtl/rof_pack.sv
module rof_pack
  import rof_pkg::*;
(
  input  logic [PIX_W-1:0] pix,
  input  logic [1:0]       order,
  input  logic [2:0]       fmt,
  output logic [PIX_W-1:0] pix_out
);
  logic [PIX_W-1:0] swapped;

  assign swapped = shuffle(order, pix);
  assign pix_out = pack_bus(fmt, swapped);
endmodule

// File: rtl/rof_sigline.sv
module rof_sigline #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] inv,
  input  logic [N-1:0] neg,
  input  logic [N-1:0] dis,
  output logic [N-1:0] pin
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic level;
    logic rise_q;
    logic fall_q;

    assign level = (dis[i] ? 1'b0 : raw[i]) ^ inv[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rise_q <= 1'b0;
      else if (clear) rise_q <= 1'b0;
      else            rise_q <= level;
    end

    // Retimes the rising-edge value onto the falling edge.
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) fall_q <= 1'b0;
      else        fall_q <= rise_q;
    end

    assign pin[i] = neg[i] ? fall_q : rise_q;
  end
endmodule

// File: rtl/rgb_out_fmt.sv
module rgb_out_fmt
  import rof_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          RD_W    = 32,
  parameter logic [31:0] ID_WORD = 32'h00647069
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [RD_W-1:0]   cfg_rdata,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              de_in,
  output logic [PIX_W-1:0]  vid_data,
  output logic              vid_hsync,
  output logic              vid_vsync,
  output logic              vid_oe,
  output logic              vid_pclk
);
  localparam int NSIG = 3;

  ctrl_t            ctrl;
  logic             start;
  logic             clear;
  logic [PIX_W-1:0] packed_pix;
  logic [PIX_W-1:0] pix_q;
  logic             oe_raw;
  logic [NSIG-1:0]  pin_v;

  rof_regs #(
    .ADDR_W (ADDR_W),
    .RD_W   (RD_W),
    .ID_WORD(ID_WORD)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_addr (cfg_addr),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .ctrl     (ctrl),
    .start    (start)
  );

  rof_pack u_pack (
    .pix    (pix_in),
    .order  (ctrl.order),
    .fmt    (ctrl.fmt),
    .pix_out(packed_pix)
  );

  assign clear = ~ctrl.enable | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pix_q <= '0;
    else if (clear) pix_q <= '0;
    else            pix_q <= packed_pix;
  end

  assign oe_raw = ctrl.oe_mode ? de_in : (hs_in | vs_in);

  rof_sigline #(.N(NSIG)) u_sig (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear),
    .raw  ({hs_in, vs_in, oe_raw}),
    .inv  ({ctrl.hs_inv, ctrl.vs_inv, ctrl.oe_inv}),
    .neg  ({ctrl.hs_neg, ctrl.vs_neg, ctrl.oe_neg}),
    .dis  ({ctrl.hs_dis, ctrl.vs_dis, ctrl.oe_dis}),
    .pin  (pin_v)
  );

  assign vid_data  = ctrl.enable ? pix_q : '0;
  assign vid_hsync = ctrl.enable & pin_v[2];
  assign vid_vsync = ctrl.enable & pin_v[1];
  assign vid_oe    = ctrl.enable & pin_v[0];
  assign vid_pclk  = ctrl.enable & (clk ^ ctrl.pclk_inv);
endmodule

// File: rtl/rgb_out_fmt_chk.sv
module rgb_out_fmt_chk
  import rof_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          RD_W    = 32,
  parameter logic [31:0] ID_WORD = 32'h00647069
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              cfg_we,
  input logic [RD_W-1:0]   cfg_rdata,
  input logic [PIX_W-1:0]  pix_in,
  input logic [PIX_W-1:0]  vid_data,
  input logic              vid_hsync,
  input logic              vid_vsync,
  input logic              vid_oe,
  input logic              vid_pclk,
  input ctrl_t             ctrl,
  input logic              start
);
  p_id_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr != '0) |-> (cfg_rdata == RD_W'(ID_WORD)));

  p_passthru_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.enable && !start && !cfg_we && ctrl.fmt == 3'd6 && ctrl.order == 2'd0)
    |=> (vid_data == $past(pix_in)));

  p_zero_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.enable && !cfg_we && (ctrl.fmt == 3'd0 || ctrl.fmt == 3'd7))
    |=> (vid_data == '0));

  p_dis_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.enable && !start && !cfg_we && ctrl.hs_dis)
    |=> (vid_hsync == $past(ctrl.hs_inv)));

  p_off_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.enable |-> (vid_data == '0 && !vid_hsync && !vid_vsync && !vid_oe && !vid_pclk));

  p_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (vid_data == '0));
endmodule

bind rgb_out_fmt rgb_out_fmt_chk #(
  .ADDR_W (ADDR_W),
  .RD_W   (RD_W),
  .ID_WORD(ID_WORD)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_addr (cfg_addr),
  .cfg_we   (cfg_we),
  .cfg_rdata(cfg_rdata),
  .pix_in   (pix_in),
  .vid_data (vid_data),
  .vid_hsync(vid_hsync),
  .vid_vsync(vid_vsync),
  .vid_oe   (vid_oe),
  .vid_pclk (vid_pclk),
  .ctrl     (ctrl),
  .start    (start)
);

// File: tb/rgb_out_fmt_tb.sv
`timescale 1ns/100ps
module rgb_out_fmt_tb;
  localparam int NV = 16;
  localparam logic [31:0] ID = 32'h00647069;

  // Stimulus table: control word, pixel, {hs,vs,de}
  localparam logic [16:0] V_CTRL [NV] = '{
    17'h13001, 17'h17001, 17'h1B001, 17'h1F001,
    17'h10801, 17'h15001, 17'h11801, 17'h12001,
    17'h1E801, 17'h10001, 17'h13801, 17'h13781,
    17'h03001, 17'h03081, 17'h1320F, 17'h13071};
  localparam logic [23:0] V_PIX [NV] = '{
    24'hA5C33C, 24'h123456, 24'h89ABCD, 24'hFE0180,
    24'hF0F0F0, 24'h7F80FF, 24'hFFFFFF, 24'hC3A5E7,
    24'h5A5A5A, 24'hFFFFFF, 24'hABCDEF, 24'h000001,
    24'h0F0F0F, 24'h0F0F0F, 24'h00FF00, 24'h314159};
  localparam logic [2:0] V_SIG [NV] = '{
    3'b101, 3'b010, 3'b111, 3'b000,
    3'b100, 3'b001, 3'b011, 3'b110,
    3'b101, 3'b111, 3'b000, 3'b010,
    3'b010, 3'b000, 3'b111, 3'b111};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic        cfg_we = 1'b0;
  logic [16:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [23:0] pix_in = '0;
  logic        hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
  logic [23:0] vid_data;
  logic        vid_hsync, vid_vsync, vid_oe, vid_pclk;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rgb_out_fmt u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .vid_data(vid_data), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync),
    .vid_oe(vid_oe), .vid_pclk(vid_pclk));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [16:0] d);
    @(posedge clk); #1;
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_addr = '0;
  endtask

  // Drive after an edge, return 2.5 ns past the capture edge.
  task automatic apply(input logic [23:0] p, input logic [2:0] s);
    @(posedge clk); #1;
    pix_in = p; {hs_in, vs_in, de_in} = s;
    @(posedge clk); #2.5;
  endtask

  function automatic logic [7:0] chan(input logic [23:0] p, input int idx);
    return p[23 - 8*idx -: 8];
  endfunction

  function automatic logic [23:0] place(input logic [7:0] v, input int w, input int lo);
    logic [23:0] t;
    t = 24'(v) >> (8 - w);
    return t << lo;
  endfunction

  function automatic logic [23:0] model_pix(input logic [16:0] c, input logic [23:0] p);
    int src [3];
    logic [7:0] s0, s1, s2;
    if (!c[0]) return '0;
    case (c[15:14])
      2'd0: src = '{0, 1, 2};
      2'd1: src = '{2, 1, 0};
      2'd2: src = '{1, 0, 2};
      default: src = '{2, 0, 1};
    endcase
    s0 = chan(p, src[0]); s1 = chan(p, src[1]); s2 = chan(p, src[2]);
    case (c[13:11])
      3'd1: return place(s0, 5, 11) | place(s1, 6, 5) | place(s2, 5, 0);
      3'd2: return place(s0, 5, 16) | place(s1, 6, 8) | place(s2, 5, 0);
      3'd3: return place(s0, 5, 17) | place(s1, 6, 8) | place(s2, 5, 1);
      3'd4: return place(s0, 6, 12) | place(s1, 6, 6) | place(s2, 6, 0);
      3'd5: return place(s0, 6, 16) | place(s1, 6, 8) | place(s2, 6, 0);
      3'd6: return place(s0, 8, 16) | place(s1, 8, 8) | place(s2, 8, 0);
      default: return '0;
    endcase
  endfunction

  // Returns {hsync, vsync, oe}
  function automatic logic [2:0] model_sig(input logic [16:0] c, input logic [2:0] s);
    logic oe_src;
    if (!c[0]) return '0;
    oe_src = c[16] ? s[0] : (s[2] | s[1]);
    return {(c[3] ? 1'b0 : s[2]) ^ c[9],
            (c[2] ? 1'b0 : s[1]) ^ c[8],
            (c[1] ? 1'b0 : oe_src) ^ c[7]};
  endfunction

  function automatic string vtag(input int i);
    if (i < 4)   return "R3";
    if (i < 9)   return "R4";
    if (i < 11)  return "R5";
    if (i == 11) return "R7";
    if (i < 14)  return "R11";
    if (i == 14) return "R9";
    return "R10";
  endfunction

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.5;
    // R14 reset state
    check("R14 data", 32'(vid_data), 32'h0);
    check("R14 pins", {28'h0, vid_hsync, vid_vsync, vid_oe, vid_pclk}, 32'h0);
    check("R14 ctrl", cfg_rdata, 32'h0);

    // Table walk; R6 aligned one-cycle latency on every vector
    for (int i = 0; i < NV; i++) begin
      logic [2:0] es;
      wr(8'h00, V_CTRL[i]);
      apply(V_PIX[i], V_SIG[i]);
      es = model_sig(V_CTRL[i], V_SIG[i]);
      check({vtag(i), " R6 data"}, 32'(vid_data), 32'(model_pix(V_CTRL[i], V_PIX[i])));
      check({vtag(i), " R6 syncs"}, {29'h0, vid_hsync, vid_vsync, vid_oe}, {29'h0, es});
      check("R8 pclk low phase", {31'h0, vid_pclk}, {31'h0, V_CTRL[i][10]});
    end

    // R1 readback and ID
    wr(8'h00, 17'h13781);
    cfg_addr = 8'h00; #0.5;
    check("R1 ctrl readback", cfg_rdata, 32'h00013781);
    cfg_addr = 8'h04; #0.5;
    check("R1 id 04", cfg_rdata, ID);
    cfg_addr = 8'hFF; #0.5;
    check("R1 id FF", cfg_rdata, ID);
    cfg_addr = 8'h00;

    // R2 write elsewhere ignored
    wr(8'h00, 17'h13001);
    apply(24'h665544, 3'b111);
    wr(8'h04, 17'h00000);
    #0.5;
    check("R2 ctrl kept", cfg_rdata, 32'h00013001);
    @(posedge clk); #2.5;
    check("R2 data kept", 32'(vid_data), 32'h665544);

    // R6 no early change before capture edge
    @(posedge clk); #1;
    pix_in = 24'h0A0B0C;
    #2.5;
    check("R6 before edge", 32'(vid_data), 32'h665544);
    @(posedge clk); #0.5;
    check("R6 after edge", 32'(vid_data), 32'h0A0B0C);

    // R10 falling-edge launch on hsync
    wr(8'h00, 17'h13041);
    apply(24'h0, 3'b000);
    @(posedge clk); #1;
    hs_in = 1'b1;
    @(posedge clk); #0.5;
    check("R10 hs held before fall", {31'h0, vid_hsync}, 32'h0);
    #2;
    check("R10 hs after fall", {31'h0, vid_hsync}, 32'h1);
    wr(8'h00, 17'h13001);
    apply(24'h0, 3'b000);
    @(posedge clk); #1;
    hs_in = 1'b1;
    @(posedge clk); #0.5;
    check("R10 rising launch", {31'h0, vid_hsync}, 32'h1);

    // R12 disabled: all outputs zero from the write edge
    apply(24'h777777, 3'b111);
    wr(8'h00, 17'h13780);
    check("R12 data", 32'(vid_data), 32'h0);
    check("R12 pins high phase", {28'h0, vid_hsync, vid_vsync, vid_oe, vid_pclk}, 32'h0);
    #2;
    check("R12 pins low phase", {28'h0, vid_hsync, vid_vsync, vid_oe, vid_pclk}, 32'h0);

    // R13 restart clears first cycle
    pix_in = 24'h3C3C3C;
    wr(8'h00, 17'h13001);
    @(posedge clk); #0.5;
    check("R13 cleared cycle", 32'(vid_data), 32'h0);
    @(posedge clk); #0.5;
    check("R13 flowing", 32'(vid_data), 32'h3C3C3C);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule